// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between the clock sources and the output buffers of a clock generator. It stops and restarts groups of output clocks on request and never emits a shortened or lengthened pulse. A CPU group of true/complement pairs is clocked by `cpu_clk`. A single-ended PCI group, made of always-stoppable outputs and a few outputs that can be set free-running, is clocked by `pci_clk`. Active-low stop requests first pass through a synchronizer in each clock domain. A register enable is then loaded only while the affected output is already sitting at its stopped level, so the gated clock can only be cut or restored at a clean boundary.

Configuration inputs choose, for each output, whether it obeys the stop request, whether it is enabled, and whether power-down sends the CPU pairs to high impedance. The CPU pads are not modelled here: high impedance is given as an output-enable flag.

Top module: `clkstop_gate`

## Requirements
- R1: After `cpu_stop_n` goes low, a stoppable CPU pair keeps toggling through the low phase that follows the second falling edge of `cpu_clk`. From the low phase after the third falling edge it is held.
- R2: A held CPU pair drives `cpu_t`=1 and `cpu_c`=0. A pair whose `cpu_stoppable` bit is 0 keeps running (`cpu_t`=0, `cpu_c`=1 in the low phase of `cpu_clk`) while `cpu_stop_n` is low.
- R3: After `cpu_stop_n` returns high, a stopped pair is still held in the low phase after the second falling edge of `cpu_clk` and is running again in the low phase after the third falling edge.
- R4: The effective PCI stop is `pci_stop_n` AND `pci_stop_reg`: if either is 0, the stoppable PCI outputs stop low, and `pci_run_stat` is 0 exactly when either is 0.
- R5: After the effective PCI stop goes low, the stoppable PCI outputs are still high in the high phase after the second rising edge of `pci_clk` and low in the high phase after the third. Release follows the same count: low after the second rising edge, high again after the third.
- R6: A `pcif_stoppable` bit of 1 makes that free-runnable PCI output obey the PCI stop. A bit of 0 keeps it toggling during a stop.
- R7: With `pd_n` held low, every CPU pair is held after the same falling-edge count as R1, whatever its `cpu_stoppable` bit or the state of `cpu_stop_n`. Every PCI output is low after three rising edges of `pci_clk`, whatever its `pcif_stoppable` bit.
- R8: While power-down is in effect and `pd_hiz`=1, `cpu_oe` is 0. Otherwise `cpu_oe` is 1.
- R9: An enable bit of 0 (`cpu_en`, `pci_en`, `pcif_en`) forces that output low: both `cpu_t` and `cpu_c` for a CPU pair, regardless of the stop inputs.
- R10: While `rst_n` is low, all synchronizers read "no request", every enabled output follows its source clock, and `cpu_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | PCI source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low CPU stop request |
| pci_stop_n | input | 1 | Active-low PCI stop request pin |
| pci_stop_reg | input | 1 | Register PCI run bit, 0 stops |
| pd_n | input | 1 | Active-low power-down request |
| pd_hiz | input | 1 | 1: CPU pairs go high impedance in power-down |
| cpu_stoppable | input | N_CPU | Per pair: 1 obeys CPU stop |
| cpu_en | input | N_CPU | Per pair enable, 0 forces low |
| pci_en | input | N_PCI | Per PCI output enable |
| pcif_stoppable | input | N_PCIF | Per free-runnable output: 1 obeys PCI stop |
| pcif_en | input | N_PCIF | Per free-runnable output enable |
| cpu_t | output | N_CPU | Gated true CPU clocks |
| cpu_c | output | N_CPU | Gated complement CPU clocks |
| cpu_oe | output | N_CPU | CPU pair output-enable flag |
| pci_out | output | N_PCI | Gated PCI clocks |
| pcif_out | output | N_PCIF | Gated free-runnable PCI clocks |
| pci_run_stat | output | 1 | Effective PCI run status |

## Verification
A release of the CPU stop and an assertion of power-down can reach the same rising edge of `cpu_clk`. The bench provokes this by raising `cpu_stop_n` and lowering `pd_n` in the same instant while pair 0 is stopped and pair 1 is free-running. It judges that pair 0 never resumes and that pair 1 is held on the same edge that the release would otherwise have used. It also judges that power-down then forces every PCI output low, even though all of them were set to free-running.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // next value of a CPU hold register (1 = held at stopped level)
  function automatic logic cpu_hold_next(input logic stop_req,
                                         input logic stoppable,
                                         input logic pd_req);
    return pd_req | (stop_req & stoppable);
  endfunction

  // next value of a PCI gate register (1 = clock passes)
  function automatic logic pci_gate_next(input logic stop_req,
                                         input logic stoppable,
                                         input logic pd_req);
    return ~(pd_req | (stop_req & stoppable));
  endfunction

  // next value of a CPU pad enable flag
  function automatic logic cpu_oe_next(input logic pd_req,
                                       input logic hiz_sel);
    return ~(pd_req & hiz_sel);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clkstop_cpu_pair.sv
`timescale 1ns/1ps
module clkstop_cpu_pair
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic pd_req,
  input  logic stoppable,
  input  logic enable,
  input  logic hiz_sel,
  output logic clk_t,
  output logic clk_c,
  output logic oe,
  output logic hold
);
  logic hold_q;
  logic oe_q;

  // loaded on the rising edge: the true output is high, the complement low,
  // i.e. both already sit at their stopped levels when the hold changes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      hold_q <= cpu_hold_next(stop_req, stoppable, pd_req);
      oe_q   <= cpu_oe_next(pd_req, hiz_sel);
    end
  end

  assign clk_t = enable & (clk | hold_q);
  assign clk_c = enable & ~clk & ~hold_q;
  assign oe    = oe_q;
  assign hold  = hold_q;
endmodule

// File: rtl/clkstop_pci_bank.sv
`timescale 1ns/1ps
module clkstop_pci_bank
  import clkstop_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             pd_req,
  input  logic [WIDTH-1:0] stoppable,
  input  logic [WIDTH-1:0] enable,
  output logic [WIDTH-1:0] clk_out,
  output logic [WIDTH-1:0] gate
);
  logic [WIDTH-1:0] gate_q;

  // loaded on the falling edge, while the output is already low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '1;
    end else begin
      for (int k = 0; k < WIDTH; k++)
        gate_q[k] <= pci_gate_next(stop_req, stoppable[k], pd_req);
    end
  end

  assign clk_out = {WIDTH{clk}} & gate_q & enable;
  assign gate    = gate_q;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int N_CPU       = 2,
  parameter int N_PCI       = 6,
  parameter int N_PCIF      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpu_clk,
  input  logic              pci_clk,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pci_stop_reg,
  input  logic              pd_n,
  input  logic              pd_hiz,
  input  logic [N_CPU-1:0]  cpu_stoppable,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_PCIF-1:0] pcif_en,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic [N_PCI-1:0]  pci_out,
  output logic [N_PCIF-1:0] pcif_out,
  output logic              pci_run_stat
);
  localparam int REQ_W = 2;

  // named internal events, observed by the checker
  logic             cpu_clk_inv;
  logic [REQ_W-1:0] cpu_sync_q;
  logic [REQ_W-1:0] pci_sync_q;
  logic             cpu_stop_req;
  logic             cpu_pd_req;
  logic             pci_stop_eff_n;
  logic             pci_stop_req;
  logic             pci_pd_req;
  logic [N_CPU-1:0] cpu_hold;
  logic [N_PCI-1:0] pci_gate;
  logic [N_PCIF-1:0] pcif_gate;

  // CPU domain: requests counted on falling edges of cpu_clk
  // (rising edges of the complement output)
  assign cpu_clk_inv = ~cpu_clk;

  clkstop_sync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_W)) u_cpu_sync (
    .clk   (cpu_clk_inv),
    .rst_n (rst_n),
    .d     ({pd_n, cpu_stop_n}),
    .q     (cpu_sync_q)
  );

  assign cpu_stop_req = ~cpu_sync_q[0];
  assign cpu_pd_req   = ~cpu_sync_q[1];

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clkstop_cpu_pair u_pair (
      .clk       (cpu_clk),
      .rst_n     (rst_n),
      .stop_req  (cpu_stop_req),
      .pd_req    (cpu_pd_req),
      .stoppable (cpu_stoppable[i]),
      .enable    (cpu_en[i]),
      .hiz_sel   (pd_hiz),
      .clk_t     (cpu_t[i]),
      .clk_c     (cpu_c[i]),
      .oe        (cpu_oe[i]),
      .hold      (cpu_hold[i])
    );
  end

  // PCI domain: pin and register bit combined before synchronizing
  assign pci_stop_eff_n = pci_stop_n & pci_stop_reg;
  assign pci_run_stat   = pci_stop_eff_n;

  clkstop_sync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_W)) u_pci_sync (
    .clk   (pci_clk),
    .rst_n (rst_n),
    .d     ({pd_n, pci_stop_eff_n}),
    .q     (pci_sync_q)
  );

  assign pci_stop_req = ~pci_sync_q[0];
  assign pci_pd_req   = ~pci_sync_q[1];

  clkstop_pci_bank #(.WIDTH(N_PCI)) u_pci (
    .clk       (pci_clk),
    .rst_n     (rst_n),
    .stop_req  (pci_stop_req),
    .pd_req    (pci_pd_req),
    .stoppable ({N_PCI{1'b1}}),
    .enable    (pci_en),
    .clk_out   (pci_out),
    .gate      (pci_gate)
  );

  clkstop_pci_bank #(.WIDTH(N_PCIF)) u_pcif (
    .clk       (pci_clk),
    .rst_n     (rst_n),
    .stop_req  (pci_stop_req),
    .pd_req    (pci_pd_req),
    .stoppable (pcif_stoppable),
    .enable    (pcif_en),
    .clk_out   (pcif_out),
    .gate      (pcif_gate)
  );
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
module clkstop_gate_chk #(
  parameter int N_CPU = 2,
  parameter int N_PCI = 6
) (
  input logic             cpu_clk,
  input logic             pci_clk,
  input logic             rst_n,
  input logic             cpu_stop_req,
  input logic             cpu_pd_req,
  input logic             pci_stop_req,
  input logic             pd_hiz,
  input logic [N_CPU-1:0] cpu_stoppable,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_CPU-1:0] cpu_hold,
  input logic [N_CPU-1:0] cpu_t,
  input logic [N_CPU-1:0] cpu_c,
  input logic [N_CPU-1:0] cpu_oe,
  input logic [N_PCI-1:0] pci_en,
  input logic [N_PCI-1:0] pci_gate,
  input logic [N_PCI-1:0] pci_out
);
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
    // R1
    cpu_hold_cause_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $rose(cpu_hold[i]) |-> $past(cpu_pd_req || (cpu_stop_req && cpu_stoppable[i])));
    // R2
    cpu_held_level_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      (cpu_hold[i] && cpu_en[i]) |-> (cpu_t[i] && !cpu_c[i]));
    // R7
    cpu_pd_hold_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      $past(cpu_pd_req) |-> cpu_hold[i]);
    // R8
    cpu_hiz_cause_chk: assert property (@(posedge cpu_clk) disable iff (!rst_n)
      !cpu_oe[i] |-> $past(cpu_pd_req && pd_hiz));
    // R9
    cpu_disable_low_chk: assert property (@(negedge cpu_clk) disable iff (!rst_n)
      !cpu_en[i] |-> (!cpu_t[i] && !cpu_c[i]));
  end

  for (genvar j = 0; j < N_PCI; j++) begin : g_pci_chk
    // R4
    pci_stop_gate_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
      $past(pci_stop_req) |-> !pci_gate[j]);
    // R5
    pci_stop_low_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
      !pci_gate[j] |-> !pci_out[j]);
    // R5
    pci_run_high_chk: assert property (@(negedge pci_clk) disable iff (!rst_n)
      (pci_gate[j] && pci_en[j]) |-> pci_out[j]);
  end
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI)) u_chk (
  .cpu_clk       (cpu_clk),
  .pci_clk       (pci_clk),
  .rst_n         (rst_n),
  .cpu_stop_req  (cpu_stop_req),
  .cpu_pd_req    (cpu_pd_req),
  .pci_stop_req  (pci_stop_req),
  .pd_hiz        (pd_hiz),
  .cpu_stoppable (cpu_stoppable),
  .cpu_en        (cpu_en),
  .cpu_hold      (cpu_hold),
  .cpu_t         (cpu_t),
  .cpu_c         (cpu_c),
  .cpu_oe        (cpu_oe),
  .pci_en        (pci_en),
  .pci_gate      (pci_gate),
  .pci_out       (pci_out)
);

// File: tb/clkstop_gate_test.sv
`timescale 1ns/1ps
module clkstop_gate_test;
  logic       cpu_clk = 1'b0;
  logic       pci_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_stop_n = 1'b1;
  logic       pci_stop_n = 1'b1;
  logic       pci_stop_reg = 1'b1;
  logic       pd_n = 1'b1;
  logic       pd_hiz = 1'b0;
  logic [1:0] cpu_stoppable = 2'b01;
  logic [1:0] cpu_en = 2'b11;
  logic [5:0] pci_en = 6'h3F;
  logic [1:0] pcif_stoppable = 2'b00;
  logic [1:0] pcif_en = 2'b11;
  logic [1:0] cpu_t, cpu_c, cpu_oe;
  logic [5:0] pci_out;
  logic [1:0] pcif_out;
  logic       pci_run_stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 cpu_clk = ~cpu_clk;   // 200 MHz
  always #7.5 pci_clk = ~pci_clk;

  clkstop_gate uut (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .rst_n(rst_n),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pci_stop_reg(pci_stop_reg),
    .pd_n(pd_n), .pd_hiz(pd_hiz), .cpu_stoppable(cpu_stoppable), .cpu_en(cpu_en),
    .pci_en(pci_en), .pcif_stoppable(pcif_stoppable), .pcif_en(pcif_en),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .pci_out(pci_out),
    .pcif_out(pcif_out), .pci_run_stat(pci_run_stat)
  );

  // per-pair state {oe,t,c} sampled in the low phase of cpu_clk
  localparam logic [2:0] RUN  = 3'b101;
  localparam logic [2:0] HELD = 3'b110;
  localparam logic [2:0] HIZ  = 3'b010;
  localparam logic [2:0] OFF  = 3'b100;

  typedef struct {
    string      req;
    int         kind;   // 0 cpu pairs, 1 pci group, 2 status
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  item_t it;
  logic [7:0] act;

  // monitor: pops expected items and compares against the outputs now
  always begin
    wait (sb.size() > 0);
    it = sb.pop_front();
    case (it.kind)
      0:       act = {2'b00, cpu_oe[1], cpu_t[1], cpu_c[1], cpu_oe[0], cpu_t[0], cpu_c[0]};
      1:       act = {pcif_out, pci_out};
      default: act = {7'd0, pci_run_stat};
    endcase
    checks++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s kind=%0d actual=%h expected=%h at %0t", it.req, it.kind, act, it.exp, $time);
    end
  end

  // driver side
  task automatic push(input string req, input int kind, input logic [7:0] exp);
    item_t x;
    x.req = req; x.kind = kind; x.exp = exp;
    sb.push_back(x);
  endtask
  task automatic exp_cpu(input string req, input logic [2:0] p1, input logic [2:0] p0);
    push(req, 0, {2'b00, p1, p0});
  endtask
  task automatic cpu_low(input int n);
    repeat (n) @(negedge cpu_clk);
    #1.25;
  endtask
  task automatic cpu_drive_point();
    @(posedge cpu_clk);
    #1;
  endtask
  task automatic pci_high(input int n);
    repeat (n) @(posedge pci_clk);
    #3;
  endtask
  task automatic pci_drive_point();
    @(negedge pci_clk);
    #2;
  endtask

  initial begin
    // R10: reset state
    cpu_low(2);
    exp_cpu("R10 reset cpu", RUN, RUN);
    pci_high(1);
    push("R10 reset pci", 1, 8'hFF);
    cpu_drive_point();
    rst_n = 1'b1;
    cpu_low(4);

    // R1/R2: pair 0 stoppable, pair 1 free-running
    cpu_drive_point();
    cpu_stop_n = 1'b0;
    cpu_low(2);
    exp_cpu("R1 still running after two falling edges", RUN, RUN);
    cpu_low(1);
    exp_cpu("R1 held after third falling edge", RUN, HELD);
    cpu_low(5);
    exp_cpu("R2 held levels, free pair runs", RUN, HELD);

    // R3: release
    cpu_drive_point();
    cpu_stop_n = 1'b1;
    cpu_low(2);
    exp_cpu("R3 still held after two falling edges", RUN, HELD);
    cpu_low(1);
    exp_cpu("R3 running after third falling edge", RUN, RUN);

    // R2: swapped stoppable selection
    cpu_drive_point();
    cpu_stoppable = 2'b10;
    cpu_stop_n = 1'b0;
    cpu_low(5);
    exp_cpu("R2 pair1 stoppable", HELD, RUN);
    cpu_drive_point();
    cpu_stop_n = 1'b1;
    cpu_low(5);

    // R5/R6: PCI pin stop, pcif0 stoppable
    pcif_stoppable = 2'b01;
    pci_drive_point();
    pci_stop_n = 1'b0;
    pci_high(2);
    push("R5 pci still high after two rising edges", 1, 8'hFF);
    pci_high(1);
    push("R5 R6 pci stopped low, pcif1 free", 1, 8'h80);
    push("R4 status low on pin stop", 2, 8'h00);
    pci_drive_point();
    pci_stop_n = 1'b1;
    pci_high(2);
    push("R5 pci still stopped after two rising edges", 1, 8'h80);
    pci_high(1);
    push("R5 pci resumed", 1, 8'hFF);

    // R4/R6: register stop bit, pcif1 stoppable
    pcif_stoppable = 2'b10;
    pci_drive_point();
    pci_stop_reg = 1'b0;
    pci_high(4);
    push("R4 R6 register stop", 1, 8'h40);
    push("R4 status low on register stop", 2, 8'h00);
    pci_drive_point();
    pci_stop_reg = 1'b1;
    pci_high(4);
    push("R4 register release", 1, 8'hFF);
    push("R4 status high", 2, 8'h01);

    // R9: enables force low
    cpu_drive_point();
    cpu_en = 2'b01;
    pci_en = 6'b111110;
    pcif_en = 2'b01;
    cpu_low(2);
    exp_cpu("R9 cpu pair disabled", OFF, RUN);
    pci_high(1);
    push("R9 pci outputs disabled", 1, 8'h7E);
    cpu_drive_point();
    cpu_en = 2'b11;
    pci_en = 6'h3F;
    pcif_en = 2'b11;

    // R7: stop release and power-down in the same instant
    cpu_stoppable = 2'b01;
    pcif_stoppable = 2'b00;
    cpu_drive_point();
    cpu_stop_n = 1'b0;
    cpu_low(4);
    exp_cpu("R1 pair0 held before power-down", RUN, HELD);
    cpu_drive_point();
    cpu_stop_n = 1'b1;
    pd_n = 1'b0;
    cpu_low(2);
    exp_cpu("R7 power-down not yet taken", RUN, HELD);
    cpu_low(1);
    exp_cpu("R7 power-down holds both pairs", HELD, HELD);
    cpu_low(4);
    exp_cpu("R7 pair0 never resumed", HELD, HELD);
    pci_high(4);
    push("R7 power-down stops free pci outputs", 1, 8'h00);

    // R8: high impedance selection
    cpu_drive_point();
    pd_hiz = 1'b1;
    cpu_low(2);
    exp_cpu("R8 oe low in power-down", HIZ, HIZ);
    cpu_drive_point();
    pd_n = 1'b1;
    cpu_low(4);
    exp_cpu("R8 R7 power-up restores oe and clocks", RUN, RUN);
    pci_high(4);
    push("R7 pci resumed after power-down", 1, 8'hFF);

    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule